// File: doc/BRIEF.md
# Banked Block Refill Sequencer

This controller fetches one cache block of four words from a main memory that sits behind a slower bus. It accepts a block address with a start strobe. It spends one bus cycle presenting the address. It then starts the DRAM accesses, waits out the fixed access latency, and streams the block back one word per bus cycle. Each returned word comes with its position in the block and a valid strobe. A one-cycle completion pulse follows the last word.

A build-time mode parameter selects how the memory is organised:

- **Interleaved mode.** The memory is four one-word banks. All four banks are started together and then drained in bank order. A refill takes 1 + 15 + 4 = 20 bus cycles.
- **Sequential mode.** The memory is a single one-word bank. It is accessed four times in turn, and each access is followed by its word transfer. A refill takes 1 + 4×15 + 4 = 65 bus cycles.

A latency register keeps the length of the most recent refill, so the two organisations can be compared directly.

Top module: `refill_seq`

## Requirements
- R1: After reset, and whenever rst_ni is low, the outputs are in these states:
  - busy_o, mem_addr_vld_o, mem_req_o, word_vld_o and done_o are low.
  - last_lat_o is zero.
- R2: When start_i is accepted in the idle state, the address phase follows.
  - The address phase lasts exactly ADDR_CYC cycles.
  - It begins in the cycle after the accepting edge.
  - mem_addr_vld_o is high for the whole phase, and mem_addr_o carries the block address.
  - mem_addr_vld_o is low at all other times.
- R3: In interleaved mode (INTERLEAVE=1), all WORDS bits of mem_req_o go high together for exactly one cycle. This is the first cycle after the address phase. mem_addr_o then equals the block address.
- R4: In interleaved mode, word_vld_o is high for WORDS consecutive cycles. The first of these comes ACCESS_LAT cycles after the request cycle.
  - word_idx_o counts 0, 1, 2, 3 across those cycles.
  - word_o is the data of bank word_idx_o. Bank b sits at bits [b*DATA_W +: DATA_W] of mem_rdata_i.
- R5: In interleaved mode with the default parameters, done_o is high in bus cycle 21, counting the address cycle as cycle 1. This is the cycle after the last word.
- R6: In sequential mode (INTERLEAVE=0), there is a single request bit and four accesses in order.
  - Access i raises mem_req_o for one cycle.
  - Its word address is mem_addr_o = {block address, i[1:0]}.
  - ACCESS_LAT cycles later, word i is delivered with word_idx_o = i.
  - The next request follows in the cycle after that word.
  - With the default parameters, done_o is high in cycle 66.
- R7: start_i is ignored while busy_o is high. A start pulse during a refill changes neither the address used nor the data returned. After the refill no second refill starts.
- R8: done_o is a single-cycle pulse. busy_o is low in the cycle after done_o.
- R9: When done_o rises, last_lat_o shows the number of cycles from the address cycle through the last word: 20 in interleaved mode and 65 in sequential mode with the defaults. last_lat_o holds that value until the next refill completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Refill request, taken only when idle |
| blk_addr_i | input | BLK_AW | Block address, captured with start_i |
| busy_o | output | 1 | Refill in progress (address cycle through done) |
| mem_addr_o | output | MEM_AW | Address to the banks (block address, or word address in sequential mode) |
| mem_addr_vld_o | output | 1 | Address phase on the bus |
| mem_req_o | output | BANKS | Per-bank access start strobe |
| mem_rdata_i | input | BANKS*DATA_W | Bank read data, bank b in slice b |
| word_o | output | DATA_W | Returned word |
| word_idx_o | output | IDX_W | Position of word_o in the block |
| word_vld_o | output | 1 | word_o and word_idx_o valid |
| done_o | output | 1 | One-cycle pulse after the last word |
| last_lat_o | output | 32 | Length in cycles of the last completed refill |

## Verification
The bench builds two copies of the block with the default WORDS=4, ADDR_CYC=1 and ACCESS_LAT=15. One copy has INTERLEAVE=1 and the other INTERLEAVE=0, so both the 20-cycle and the 65-cycle schedules are exercised against the same bank timing model.

The bank models return poison data until a full ACCESS_LAT cycles have passed since their request. A word taken one cycle early therefore shows up as a data mismatch. Because of this, the true access latency, the per-bank request timing and the word-to-bank mapping are all checked at the ports.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_XFER,
    ST_DONE
  } refill_state_e;
endpackage

// File: rtl/refill_timer.sv
module refill_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) && $past(cnt_q) != '0 |-> cnt_q == $past(cnt_q) - 1'b1); // R4
endmodule

// File: rtl/refill_lat_cnt.sv
module refill_lat_cnt (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        run_i,
  input  logic        cap_i,
  output logic [31:0] last_o
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (clr_i)  run_q <= 32'd1;
    else if (run_i)  run_q <= run_q + 32'd1;
  end

  // captures the count of cycles up to and including the last word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_o <= '0;
    else if (cap_i)  last_o <= run_q;
  end

  AST_LAT_ONLY_ON_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(last_o) |-> $past(cap_i)); // R9
endmodule

// File: rtl/refill_word_mux.sv
module refill_word_mux #(
  parameter int BANKS  = 4,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 2
) (
  input  logic [BANKS*DATA_W-1:0] rdata_i,
  input  logic [SEL_W-1:0]        sel_i,
  output logic [DATA_W-1:0]       word_o
);
  logic [DATA_W-1:0] lane [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_lane
    assign lane[b] = rdata_i[b*DATA_W +: DATA_W];
  end

  always_comb begin
    word_o = lane[0];
    for (int b = 1; b < BANKS; b++)
      if (int'(sel_i) == b) word_o = lane[b];
  end
endmodule

// File: rtl/refill_seq.sv
module refill_seq
  import refill_pkg::*;
#(
  parameter int WORDS      = 4,
  parameter int DATA_W     = 32,
  parameter int BLK_AW     = 26,
  parameter int ADDR_CYC   = 1,
  parameter int ACCESS_LAT = 15,
  parameter bit INTERLEAVE = 1'b1,
  localparam int BANKS     = INTERLEAVE ? WORDS : 1,
  localparam int IDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int MEM_AW    = INTERLEAVE ? BLK_AW : BLK_AW + IDX_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [BLK_AW-1:0]       blk_addr_i,
  output logic                    busy_o,
  output logic [MEM_AW-1:0]       mem_addr_o,
  output logic                    mem_addr_vld_o,
  output logic [BANKS-1:0]        mem_req_o,
  input  logic [BANKS*DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0]       word_o,
  output logic [IDX_W-1:0]        word_idx_o,
  output logic                    word_vld_o,
  output logic                    done_o,
  output logic [31:0]             last_lat_o
);
  localparam int TMR_MAX = (ADDR_CYC > ACCESS_LAT) ? ADDR_CYC : ACCESS_LAT;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int SEL_W   = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam logic [TMR_W-1:0] ADDR_LD = TMR_W'(ADDR_CYC - 1);
  localparam logic [TMR_W-1:0] WAIT_LD = TMR_W'(ACCESS_LAT - 1);
  localparam logic [IDX_W-1:0] LAST_W  = IDX_W'(WORDS - 1);

  refill_state_e     st_q, st_d;
  logic [BLK_AW-1:0] blk_q;
  logic [IDX_W-1:0]  wcnt_q;
  logic              req_q;
  logic              accept, tmr_zero, tmr_load, enter_wait, wcnt_inc, last_word;
  logic [TMR_W-1:0]  tmr_val;
  logic [SEL_W-1:0]  sel;

  assign accept    = (st_q == ST_IDLE) && start_i;
  assign last_word = (st_q == ST_XFER) && (wcnt_q == LAST_W);

  always_comb begin
    st_d       = st_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    enter_wait = 1'b0;
    wcnt_inc   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d     = ST_ADDR;
        tmr_load = 1'b1;
        tmr_val  = ADDR_LD;
      end
      ST_ADDR: if (tmr_zero) begin
        st_d       = ST_WAIT;
        tmr_load   = 1'b1;
        tmr_val    = WAIT_LD;
        enter_wait = 1'b1;
      end
      ST_WAIT: if (tmr_zero) st_d = ST_XFER;
      ST_XFER: begin
        if (last_word) st_d = ST_DONE;
        else begin
          wcnt_inc = 1'b1;
          if (!INTERLEAVE) begin
            st_d       = ST_WAIT;
            tmr_load   = 1'b1;
            tmr_val    = WAIT_LD;
            enter_wait = 1'b1;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      blk_q  <= '0;
      wcnt_q <= '0;
      req_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      req_q <= enter_wait;
      if (accept) begin
        blk_q  <= blk_addr_i;
        wcnt_q <= '0;
      end else if (wcnt_inc) begin
        wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end

  refill_timer #(.W(TMR_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  refill_lat_cnt u_lat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .run_i  (st_q != ST_IDLE),
    .cap_i  (last_word),
    .last_o (last_lat_o)
  );

  if (INTERLEAVE) begin : g_banked
    assign mem_addr_o = blk_q;
    assign sel        = SEL_W'(wcnt_q);
  end else begin : g_single
    assign mem_addr_o = {blk_q, wcnt_q};
    assign sel        = '0;
  end

  refill_word_mux #(.BANKS(BANKS), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_mux (
    .rdata_i (mem_rdata_i),
    .sel_i   (sel),
    .word_o  (word_o)
  );

  assign busy_o         = (st_q != ST_IDLE);
  assign mem_addr_vld_o = (st_q == ST_ADDR);
  assign mem_req_o      = {BANKS{req_q}};
  assign word_vld_o     = (st_q == ST_XFER);
  assign word_idx_o     = wcnt_q;
  assign done_o         = (st_q == ST_DONE);

  AST_REQ_IN_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o != '0 |-> st_q == ST_WAIT && $past(st_q) != ST_WAIT); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R8
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o && $past(word_vld_o) |-> word_idx_o == $past(word_idx_o) + 1'b1); // R4
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(blk_q)); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(word_vld_o) && $past(word_idx_o) == LAST_W); // R5
endmodule

// File: tb/tb_refill_seq.sv
module tb_refill_seq;
  localparam int DW = 32, AW = 26, LAT = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  // interleaved instance signals
  logic           st_a = 1'b0;
  logic [AW-1:0]  ad_a = '0;
  logic           busy_a, avld_a, vld_a, done_a;
  logic [AW-1:0]  maddr_a;
  logic [3:0]     req_a;
  logic [4*DW-1:0] rd_a;
  logic [DW-1:0]  w_a;
  logic [1:0]     idx_a;
  logic [31:0]    lat_a;

  // sequential instance signals
  logic           st_s = 1'b0;
  logic [AW-1:0]  ad_s = '0;
  logic           busy_s, avld_s, vld_s, done_s;
  logic [AW+1:0]  maddr_s;
  logic [0:0]     req_s;
  logic [DW-1:0]  rd_s;
  logic [DW-1:0]  w_s;
  logic [1:0]     idx_s;
  logic [31:0]    lat_s;

  refill_seq #(.INTERLEAVE(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st_a), .blk_addr_i(ad_a),
    .busy_o(busy_a), .mem_addr_o(maddr_a), .mem_addr_vld_o(avld_a),
    .mem_req_o(req_a), .mem_rdata_i(rd_a), .word_o(w_a), .word_idx_o(idx_a),
    .word_vld_o(vld_a), .done_o(done_a), .last_lat_o(lat_a));

  refill_seq #(.INTERLEAVE(1'b0)) dut_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st_s), .blk_addr_i(ad_s),
    .busy_o(busy_s), .mem_addr_o(maddr_s), .mem_addr_vld_o(avld_s),
    .mem_req_o(req_s), .mem_rdata_i(rd_s), .word_o(w_s), .word_idx_o(idx_s),
    .word_vld_o(vld_s), .done_o(done_s), .last_lat_o(lat_s));

  function automatic logic [DW-1:0] mem_word(input logic [AW+1:0] wa);
    return 32'hA5000000 ^ (32'(wa) * 32'd7);
  endfunction

  // bank models: data becomes valid LAT cycles after the request cycle
  int           bc_a [4];
  logic [AW-1:0] ba_a [4];
  int           bc_s;
  logic [AW+1:0] ba_s;

  always_ff @(posedge clk) begin
    for (int b = 0; b < 4; b++) begin
      if (req_a[b]) begin bc_a[b] <= 1; ba_a[b] <= maddr_a; end
      else if (bc_a[b] != 0 && bc_a[b] < LAT) bc_a[b] <= bc_a[b] + 1;
    end
    if (req_s[0]) begin bc_s <= 1; ba_s <= maddr_s; end
    else if (bc_s != 0 && bc_s < LAT) bc_s <= bc_s + 1;
  end

  always_comb begin
    for (int b = 0; b < 4; b++)
      rd_a[b*DW +: DW] = (bc_a[b] == LAT) ? mem_word({ba_a[b], 2'(b)}) : 32'hBAD0BAD0;
    rd_s = (bc_s == LAT) ? mem_word(ba_s) : 32'hBAD0BAD0;
  end

  initial begin
    for (int b = 0; b < 4; b++) begin bc_a[b] = 0; ba_a[b] = '0; end
    bc_s = 0; ba_s = '0;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input bit sq, input int blk, input bit mid);
    int total = sq ? 65 : 20;
    int bad_req = 0, bad_word = 0, bad_done = 0, bad_avld = 0, nwords = 0, lat_seen = -1;
    @(negedge clk);
    if (sq) begin st_s = 1'b1; ad_s = AW'(blk); end
    else    begin st_a = 1'b1; ad_a = AW'(blk); end
    @(posedge clk); @(negedge clk);
    // cycle 0 after accept: address phase
    if (sq) check(avld_s && maddr_s[AW+1:2] == AW'(blk), "R2", maddr_s, blk);
    else    check(avld_a && maddr_a == AW'(blk), "R2", maddr_a, blk);
    for (int cyc = 1; cyc <= total + 2; cyc++) begin
      logic s_now = mid && (cyc == 5 || cyc == total - 1);
      if (sq) begin st_s = s_now; ad_s = AW'(blk + 1); end
      else    begin st_a = s_now; ad_a = AW'(blk + 1); end
      @(posedge clk); @(negedge clk);
      if (sq) begin
        bit rq_e = 0, vl_e = 0; int wi = 0;
        for (int i = 0; i < 4; i++) begin
          if (cyc == 1 + 16*i) begin rq_e = 1; wi = i; end
          if (cyc == 16 + 16*i) begin vl_e = 1; wi = i; end
        end
        if (avld_s) bad_avld++;
        if (req_s[0] != rq_e) bad_req++;
        if (rq_e && maddr_s != {AW'(blk), 2'(wi)}) bad_req++;
        if (vld_s != vl_e) bad_word++;
        if (vl_e && (idx_s != 2'(wi) || w_s != mem_word({AW'(blk), 2'(wi)}))) bad_word++;
        if (vl_e) nwords++;
        if (done_s != (cyc == total)) bad_done++;
        if (cyc == total) lat_seen = int'(lat_s);
        if (cyc > total && busy_s) bad_done++;
      end else begin
        bit vl_e = (cyc >= 16 && cyc <= 19);
        int wi = cyc - 16;
        if (avld_a) bad_avld++;
        if (req_a != ((cyc == 1) ? 4'hF : 4'h0)) bad_req++;
        if (cyc == 1 && maddr_a != AW'(blk)) bad_req++;
        if (vld_a != vl_e) bad_word++;
        if (vl_e && (idx_a != 2'(wi) || w_a != mem_word({AW'(blk), 2'(wi)}))) bad_word++;
        if (vl_e) nwords++;
        if (done_a != (cyc == total)) bad_done++;
        if (cyc == total) lat_seen = int'(lat_a);
        if (cyc > total && busy_a) bad_done++;
      end
    end
    check(bad_avld == 0, "R2", bad_avld, 0);
    if (sq) begin
      check(bad_req == 0, "R6", bad_req, 0);
      check(bad_word == 0 && nwords == 4, "R6", nwords, 4);
      check(bad_done == 0, "R6", bad_done, 0);
    end else begin
      check(bad_req == 0, "R3", bad_req, 0);
      check(bad_word == 0 && nwords == 4, "R4", nwords, 4);
      check(bad_done == 0, "R5", bad_done, 0);
    end
    check(lat_seen == total, "R9", lat_seen, total);
    if (mid) check(bad_word == 0 && bad_done == 0, "R7", bad_word + bad_done, 0);
    else     check(bad_done == 0, "R8", bad_done, 0);
  endtask

  localparam int NV = 5;
  localparam int VEC_BLK [NV] = '{0, 1, 26'h3FFFFFF, 12345, 26'h2AAAAAA};
  localparam bit VEC_SEQ [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam bit VEC_MID [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  initial begin : wdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy_a && !avld_a && req_a == 0 && !vld_a && !done_a && lat_a == 0, "R1", lat_a, 0);
    check(!busy_s && !avld_s && req_s == 0 && !vld_s && !done_s && lat_s == 0, "R1", lat_s, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NV; v++) run(VEC_SEQ[v], VEC_BLK[v], VEC_MID[v]);
    // R9: latency holds while idle
    repeat (5) @(negedge clk);
    check(lat_a == 32'd20, "R9", lat_a, 20);
    check(lat_s == 32'd65, "R9", lat_s, 65);
    // R1: reset in the middle of a refill
    st_a = 1'b1; ad_a = AW'(77);
    @(negedge clk); st_a = 1'b0;
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!busy_a && req_a == 0 && !vld_a && !done_a && lat_a == 0, "R1", busy_a, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    run(1'b0, 99, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule